// File: doc/BRIEF.md
# Network Controller Command and Configuration Register File

This block holds the small set of control registers that software uses to steer a network controller. It has a command register, a serial-memory access and lock register, five configuration bytes and two 16-bit PHY basic-mode registers. Writes pass through a fixed protection mask for each register, so protected bits keep their value. A write lane enable decides which bytes of a word take part.

Two writes restore every register to its default in a single clock. One is a command write with the reset bit set. The other is an access-register write that selects the reset mode. In that same cycle a one-cycle `soft_reset_o` pulse tells neighbouring logic, such as the interrupt status and mask owner, to clear its own state. The access register also has a lock mode, which opens four of the configuration bytes to writes. It also has a serial-memory mode, which drives chip select, clock and data-in pins directly from register bits and returns the data-out pin on read.

Reads are combinational from the stored state. Each read also merges in two live inputs: the receive-buffer-empty flag and the serial data-out pin.

Top module: `nic_cfg_regs`

## Requirements
- R1: After `rst_n` is released, and in the cycle in which `soft_reset_o` is high, the registers read: command 0x00, access 0x00, cfg0 0x00, cfg1 0x0C, cfg3 0x01, cfg4 0x00, cfg5 0x00, mode-control 0x1000, mode-status 0x782D.
- R2: On a write, bits set in a register's keep mask hold their old value and all other enabled bits take `wr_data`. The keep masks are: command 0xE3, access 0x31, cfg0 0xF8, cfg1 0x0C, cfg3 0x8F, cfg4 0x0A, cfg5 0x80, mode-status 0xFF3F.
- R3: A command write with bit 4 set restores every register to its R1 value on the next edge and raises `soft_reset_o` for exactly that one cycle. Command bit 4 always reads 0.
- R4: A command read returns the stored value with bit 0 ORed with `rx_buf_empty_i`.
- R5: While access bits 7:6 are 2'b10, `ee_cs_o`, `ee_sk_o` and `ee_di_o` follow access bits 3, 2 and 1, and access read bit 0 returns `ee_do_i`. In any other mode the three pins are 0 and read bit 0 is the stored bit.
- R6: An access write whose resulting bits 7:6 are 2'b01 performs the full reset of R3 and leaves the access register at 0x00.
- R7: Writes to cfg0, cfg1, cfg3 and cfg4 take effect only while access bits 7:6 are 2'b11, judged on the value before the write. Otherwise they are dropped and the register keeps its contents.
- R8: Writes to cfg5 take effect whatever the lock mode.
- R9: In the mode-control register only bits 15 and 9 are writable. All other bits keep their value.
- R10: `wr_be[0]` enables bits 7:0 and `wr_be[1]` enables bits 15:8. 8-bit registers update only when `wr_be[0]` is set and read with bits 15:8 at zero.
- R11: The address map is: 0 command, 1 access, 2 cfg0, 3 cfg1, 4 cfg3, 5 cfg4, 6 cfg5, 7 mode-control, 8 mode-status. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_be | input | DATA_W/8 | Byte lane enables |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data |
| rx_buf_empty_i | input | 1 | Live receive-buffer-empty flag |
| ee_do_i | input | 1 | Serial memory data out |
| ee_cs_o | output | 1 | Serial memory chip select |
| ee_sk_o | output | 1 | Serial memory clock |
| ee_di_o | output | 1 | Serial memory data in |
| soft_reset_o | output | 1 | One-cycle pulse after a software reset |

## Verification
The bench uses the default widths, ADDR_W = 4 and DATA_W = 16. With these, random addresses cover the nine mapped registers and the seven unmapped indices. Random lane enables reach the upper byte of the 16-bit registers and the dropped upper lane of the byte registers.

Access-register writes are weighted toward the lock and serial-memory modes, so that locked and unlocked configuration writes both occur often. The random stream also includes both reset paths, which keeps the registers returning to their defaults.

// File: rtl/nic_cfg_pkg.sv
package nic_cfg_pkg;

    localparam int NUM_BREG = 7;

    typedef enum logic [3:0] {
        IDX_CMD   = 4'd0,
        IDX_ACC   = 4'd1,
        IDX_CFG0  = 4'd2,
        IDX_CFG1  = 4'd3,
        IDX_CFG3  = 4'd4,
        IDX_CFG4  = 4'd5,
        IDX_CFG5  = 4'd6,
        IDX_BMCR  = 4'd7,
        IDX_BMSR  = 4'd8
    } reg_idx_e;

    localparam logic [1:0] MODE_RESET  = 2'b01;
    localparam logic [1:0] MODE_SERIAL = 2'b10;
    localparam logic [1:0] MODE_UNLOCK = 2'b11;

    // index 6 first: cfg5, cfg4, cfg3, cfg1, cfg0, access, command
    localparam logic [NUM_BREG-1:0][7:0] BYTE_DEF  =
        '{8'h00, 8'h00, 8'h01, 8'h0C, 8'h00, 8'h00, 8'h00};
    localparam logic [NUM_BREG-1:0][7:0] BYTE_KEEP =
        '{8'h80, 8'h0A, 8'h8F, 8'h0C, 8'hF8, 8'h31, 8'hE3};
    // lock-gated byte registers
    localparam logic [NUM_BREG-1:0] BYTE_LOCKED = 7'b0111100;

    localparam logic [15:0] BMCR_DEF  = 16'h1000;
    localparam logic [15:0] BMCR_KEEP = 16'h4CFF | 16'h3000 | 16'h0100;
    localparam logic [15:0] BMSR_DEF  = 16'h7809 | 16'h0020 | 16'h0004;
    localparam logic [15:0] BMSR_KEEP = 16'hFF3F;

    typedef struct packed {
        logic [NUM_BREG-1:0][7:0] breg;
        logic [15:0]              bmcr;
        logic [15:0]              bmsr;
        logic                     srst;
    } regs_t;

    localparam regs_t REGS_DEF = '{breg: BYTE_DEF, bmcr: BMCR_DEF,
                                   bmsr: BMSR_DEF, srst: 1'b0};

endpackage

// File: rtl/nic_cfg_merge.sv
module nic_cfg_merge #(
    parameter int W = 8
) (
    input  logic [W-1:0]   old_val,
    input  logic [W-1:0]   new_val,
    input  logic [W/8-1:0] lane_en,
    input  logic [W-1:0]   keep_mask,
    input  logic           wr_en,
    output logic [W-1:0]   merged
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign merged[b] = (wr_en && lane_en[b/8] && !keep_mask[b]) ? new_val[b] : old_val[b];
    end
endmodule

// File: rtl/nic_eeprom_port.sv
module nic_eeprom_port
    import nic_cfg_pkg::*;
(
    input  logic [7:0] acc_q,
    input  logic       ee_do_i,
    output logic       ee_cs_o,
    output logic       ee_sk_o,
    output logic       ee_di_o,
    output logic [7:0] acc_view
);
    logic serial_mode;
    assign serial_mode = (acc_q[7:6] == MODE_SERIAL);
    assign ee_cs_o     = serial_mode & acc_q[3];
    assign ee_sk_o     = serial_mode & acc_q[2];
    assign ee_di_o     = serial_mode & acc_q[1];
    assign acc_view    = serial_mode ? {acc_q[7:1], ee_do_i} : acc_q;
endmodule

// File: rtl/nic_cfg_readmux.sv
module nic_cfg_readmux
    import nic_cfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  regs_t             regs_q,
    input  logic [7:0]        acc_view,
    input  logic              rx_buf_empty_i,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(IDX_CMD):  rd_data[7:0] = regs_q.breg[0] | {7'd0, rx_buf_empty_i};
            ADDR_W'(IDX_ACC):  rd_data[7:0] = acc_view;
            ADDR_W'(IDX_CFG0),
            ADDR_W'(IDX_CFG1),
            ADDR_W'(IDX_CFG3),
            ADDR_W'(IDX_CFG4),
            ADDR_W'(IDX_CFG5): rd_data[7:0] = regs_q.breg[addr[2:0]];
            ADDR_W'(IDX_BMCR): rd_data[15:0] = regs_q.bmcr;
            ADDR_W'(IDX_BMSR): rd_data[15:0] = regs_q.bmsr;
            default:           rd_data = '0;
        endcase
    end
endmodule

// File: rtl/nic_cfg_regs.sv
module nic_cfg_regs
    import nic_cfg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                rx_buf_empty_i,
    input  logic                ee_do_i,
    output logic                ee_cs_o,
    output logic                ee_sk_o,
    output logic                ee_di_o,
    output logic                soft_reset_o
);
    localparam int LANES = DATA_W / 8;

    regs_t regs_d, regs_q;

    logic [NUM_BREG-1:0][7:0] bmerge;
    logic [NUM_BREG-1:0]      bwrite;
    logic [15:0]              bmcr_m, bmsr_m;
    logic                     unlocked;
    logic [7:0]               acc_view;

    assign unlocked = (regs_q.breg[1][7:6] == MODE_UNLOCK);

    // byte registers: lane 0 only, lock gate where selected
    for (genvar i = 0; i < NUM_BREG; i++) begin : g_breg
        assign bwrite[i] = wr_en && (reg_addr == ADDR_W'(i)) &&
                           (!BYTE_LOCKED[i] || unlocked);
        nic_cfg_merge #(.W(8)) u_merge (
            .old_val   (regs_q.breg[i]),
            .new_val   (wr_data[7:0]),
            .lane_en   (wr_be[0]),
            .keep_mask (BYTE_KEEP[i]),
            .wr_en     (bwrite[i]),
            .merged    (bmerge[i])
        );
    end

    nic_cfg_merge #(.W(16)) u_bmcr (
        .old_val   (regs_q.bmcr),
        .new_val   (wr_data[15:0]),
        .lane_en   (wr_be[1:0]),
        .keep_mask (BMCR_KEEP),
        .wr_en     (wr_en && (reg_addr == ADDR_W'(IDX_BMCR))),
        .merged    (bmcr_m)
    );

    nic_cfg_merge #(.W(16)) u_bmsr (
        .old_val   (regs_q.bmsr),
        .new_val   (wr_data[15:0]),
        .lane_en   (wr_be[1:0]),
        .keep_mask (BMSR_KEEP),
        .wr_en     (wr_en && (reg_addr == ADDR_W'(IDX_BMSR))),
        .merged    (bmsr_m)
    );

    always_comb begin
        regs_d       = regs_q;
        regs_d.srst  = 1'b0;
        regs_d.breg  = bmerge;
        regs_d.bmcr  = bmcr_m;
        regs_d.bmsr  = bmsr_m;
        regs_d.breg[0][4] = 1'b0;
        if ((bwrite[0] && wr_be[0] && wr_data[4]) ||
            (bwrite[1] && wr_be[0] && bmerge[1][7:6] == MODE_RESET)) begin
            regs_d      = REGS_DEF;
            regs_d.srst = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_DEF;
        else        regs_q <= regs_d;
    end

    nic_eeprom_port u_ee (
        .acc_q    (regs_q.breg[1]),
        .ee_do_i  (ee_do_i),
        .ee_cs_o  (ee_cs_o),
        .ee_sk_o  (ee_sk_o),
        .ee_di_o  (ee_di_o),
        .acc_view (acc_view)
    );

    nic_cfg_readmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .regs_q         (regs_q),
        .acc_view       (acc_view),
        .rx_buf_empty_i (rx_buf_empty_i),
        .addr           (reg_addr),
        .rd_data        (rd_data)
    );

    assign soft_reset_o = regs_q.srst;

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset_o |-> (regs_q.breg == BYTE_DEF && regs_q.bmcr == BMCR_DEF &&
                          regs_q.bmsr == BMSR_DEF));

    assert_status_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.bmsr & BMSR_KEEP) == (BMSR_DEF & BMSR_KEEP));

    assert_cmd_rst_bit_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.breg[0][4]);

    assert_pins_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.breg[1][7:6] != MODE_SERIAL) |-> (!ee_cs_o && !ee_sk_o && !ee_di_o));

    assert_locked_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr >= ADDR_W'(IDX_CFG0) && reg_addr <= ADDR_W'(IDX_CFG4) && !unlocked)
        |=> $stable(regs_q.breg[5:2]));

    assert_ctrl_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.bmcr & BMCR_KEEP) == (BMCR_DEF & BMCR_KEEP));

endmodule

// File: tb/nic_cfg_regs_test.sv
module nic_cfg_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_be = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rx_empty = 1'b0, ee_do = 1'b0;
    logic        ee_cs, ee_sk, ee_di, srst;

    int checks = 0, errors = 0;

    logic [7:0]  mb [0:6];
    logic [15:0] mctl, msts;
    logic        exp_srst;

    always #4 clk = ~clk;

    nic_cfg_regs uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .rd_data(rd_data),
        .rx_buf_empty_i(rx_empty), .ee_do_i(ee_do), .ee_cs_o(ee_cs),
        .ee_sk_o(ee_sk), .ee_di_o(ee_di), .soft_reset_o(srst)
    );

    function automatic logic [15:0] mrg(input logic [15:0] o, input logic [15:0] n,
                                        input logic [1:0] be, input logic [15:0] keep);
        logic [15:0] en;
        en = {{8{be[1]}}, {8{be[0]}}} & ~keep;
        return (o & ~en) | (n & en);
    endfunction

    function automatic logic [7:0] keep_of(input int a);
        case (a)
            0: return 8'hE3; 1: return 8'h31; 2: return 8'hF8; 3: return 8'h0C;
            4: return 8'h8F; 5: return 8'h0A; default: return 8'h80;
        endcase
    endfunction

    task automatic model_defaults();
        mb[0] = 8'h00; mb[1] = 8'h00; mb[2] = 8'h00; mb[3] = 8'h0C;
        mb[4] = 8'h01; mb[5] = 8'h00; mb[6] = 8'h00;
        mctl = 16'h1000; msts = 16'h782D;
    endtask

    task automatic model_write(input int a, input logic [1:0] be, input logic [15:0] d);
        logic [7:0] nv;
        exp_srst = 1'b0;
        if (a <= 6) begin
            if (!be[0]) return;
            if (a >= 2 && a <= 5 && mb[1][7:6] != 2'b11) return;
            nv = mrg({8'h00, mb[a]}, d, be, {8'hFF, keep_of(a)})[7:0];
            if ((a == 0 && d[4]) || (a == 1 && nv[7:6] == 2'b01)) begin
                model_defaults();
                exp_srst = 1'b1;
                return;
            end
            if (a == 0) nv[4] = 1'b0;
            mb[a] = nv;
        end else if (a == 7) mctl = mrg(mctl, d, be, 16'h7DFF);
        else if (a == 8) msts = mrg(msts, d, be, 16'hFF3F);
    endtask

    function automatic logic [15:0] exp_read(input int a);
        case (a)
            0: return {8'h00, mb[0] | {7'd0, rx_empty}};
            1: return (mb[1][7:6] == 2'b10) ? {8'h00, mb[1][7:1], ee_do} : {8'h00, mb[1]};
            2, 3, 4, 5, 6: return {8'h00, mb[a]};
            7: return mctl;
            8: return msts;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd(input int a, input string tag);
        reg_addr = 4'(a);
        #1;
        chk(tag, rd_data, exp_read(a));
    endtask

    task automatic chk_pins(input string tag);
        logic m;
        m = (mb[1][7:6] == 2'b10);
        chk(tag, {13'd0, ee_cs, ee_sk, ee_di}, {13'd0, m & mb[1][3], m & mb[1][2], m & mb[1][1]});
    endtask

    task automatic wr(input int a, input logic [1:0] be, input logic [15:0] d, input string tag);
        reg_addr = 4'(a); wr_be = be; wr_data = d; wr_en = 1'b1;
        model_write(a, be, d);
        @(negedge clk);
        wr_en = 1'b0;
        chk({tag, " soft_reset_o (R3)"}, {15'd0, srst}, {15'd0, exp_srst});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        model_defaults();
        exp_srst = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 and R11: defaults at every mapped address, unmapped zero
        for (int a = 0; a < 16; a++) rd(a, "R1 R11 reset default");
        chk("R1 soft_reset_o idle", {15'd0, srst}, 16'd0);

        // R4 live receive-empty
        rx_empty = 1'b1; rd(0, "R4 rx empty set");
        rx_empty = 1'b0; rd(0, "R4 rx empty clear");

        // R7 locked write dropped, R8 cfg5 accepted
        wr(2, 2'b01, 16'h0007, "R7 locked");   rd(2, "R7 cfg0 locked keeps");
        wr(6, 2'b01, 16'h007F, "R8");          rd(6, "R8 cfg5 while locked");
        wr(1, 2'b01, 16'h00C0, "R7 unlock");
        wr(2, 2'b01, 16'h00FF, "R7 unlocked"); rd(2, "R7 R2 cfg0 unlocked masked");
        wr(4, 2'b01, 16'h00FF, "R2");          rd(4, "R2 cfg3 masked");

        // R10 byte lanes on a byte register and a word register
        wr(6, 2'b10, 16'h0000, "R10");         rd(6, "R10 cfg5 upper lane only ignored");
        wr(7, 2'b01, 16'hFFFF, "R9 R10");      rd(7, "R9 R10 ctl low lane");
        wr(7, 2'b11, 16'hFFFF, "R9");          rd(7, "R9 ctl writable bits");
        wr(12, 2'b11, 16'hFFFF, "R11");        rd(12, "R11 unmapped");

        // R5 serial mode pins and data out
        wr(1, 2'b01, 16'h008E, "R5");
        chk_pins("R5 pins high");
        ee_do = 1'b1; rd(1, "R5 data out 1");
        ee_do = 1'b0; rd(1, "R5 data out 0");
        wr(1, 2'b01, 16'h000E, "R5 exit");
        chk_pins("R5 pins idle");

        // R3 command reset
        wr(0, 2'b01, 16'h001C, "R3 cmd reset");
        for (int a = 0; a < 9; a++) rd(a, "R3 defaults after cmd reset");
        wr(0, 2'b01, 16'h000C, "R3 enables"); rd(0, "R3 cmd enables, bit4 clear");

        // R6 access reset mode
        wr(1, 2'b01, 16'h00C0, "R6 unlock");
        wr(3, 2'b01, 16'h00F3, "R6 prep");
        wr(1, 2'b01, 16'h0040, "R6 access reset");
        for (int a = 0; a < 9; a++) rd(a, "R6 defaults after access reset");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int a;
            logic [15:0] d;
            a = int'($urandom % 16);
            d = 16'($urandom);
            if (a == 1 && ($urandom % 4) != 0) d[7:6] = (($urandom % 2) != 0) ? 2'b11 : 2'b10;
            if (a == 0 && ($urandom % 8) != 0) d[4] = 1'b0;
            rx_empty = 1'($urandom);
            ee_do = 1'($urandom);
            wr(a, 2'($urandom), d, "R2 R7 random");
            rd(int'($urandom % 16), "R2 R10 R11 random read");
            chk_pins("R5 random pins");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule